// File: doc/BRIEF.md
# Transform Engine Mode Word Capture and Decode

This block takes a 16-bit configuration word from a bus that, at other times, carries imaginary input samples. While the define strobe is high the word is copied into an internal register; when the strobe is low the bus is ignored and the stored word holds. The stored word is broken into control fields for a transform engine: size and data type, datapath scaling mode, window or inverse selection, overlap and input-strobe divider, and the multi-device operating mode.

Beyond plain field extraction, the block derives whether load, transform and dump may overlap in time, forcing sequential operation for the 1024-point sizes and for the isolated multi-device mode. It also flags combinations that make the engine fall into an internal test mode. All decoded outputs are registered and change together with a valid flag, so the engine never acts on a half-written word.

Top module: `xform_mode_ctl`

## Requirements
- R1: Synchronous active-high reset clears the stored word to zero and drives `cfg_valid` low; the decoded outputs then show the zero word: `size_log2`=8, complex, one-dimensional, `shift_later`=3, `max_left`=15, `win_sel`=0, forward, no overlap, `in_div`=0, `dev_mode`=0, `stage_isolate`=0, `concurrent_ok`=1, `test_mode`=0.
- R2: The word is copied from `cfg_bus` only on clock edges where `cfg_def` is high; with `cfg_def` low, bus activity leaves `cfg_word` unchanged. All 16 bits, including 15:11, appear on `cfg_word`.
- R3: `cfg_valid` is low in the cycle after any edge that samples `cfg_def` high, and goes high at the first edge that samples `cfg_def` low after it was high; at that same edge `cfg_word` and every decoded field show the last captured word. With `cfg_def` held high over several edges, the last bus value is the one kept.
- R4: Bits 2:0 select size and type: 000 256 complex, 001 512 complex, 010 1024 complex, 011 16x16 complex (`size_log2`=8, `two_dim`=1), 100 256 real, 101 512 real, 110 1024 real (`real_data`=1 for 100..110); 111 is reserved and decodes as 256 complex.
- R5: Bit 3 low gives `shift_later`=3 and `max_left`=15; bit 3 high gives `shift_later`=2 and `max_left`=14.
- R6: Bits 5:4 give `win_sel` 0 (rectangular), 1 or 2 (two tapered windows); code 3 sets `inverse`=1 and forces `win_sel`=0.
- R7: Bits 8:6 give (`overlap`,`in_div`,`dual_real`) with overlap 0=none,1=50%,2=75% and divider 0=/1,1=/2,2=/4: 000 (0,0,0), 001 (1,0,0), 010 (2,0,0), 011 (1,1,0), 100 (2,2,0), 101 (0,0,1), 110 (1,0,1), 111 (2,0,1).
- R8: Bits 10:9 appear as `dev_mode`; code 3 sets `stage_isolate`=1.
- R9: `concurrent_ok` is 1 only when the size is not a 1024-point option and `dev_mode` is 0 or 1.
- R10: `test_mode` is 1 when bits 2:0 are 111, or when bits 2:0 are 011 and bits 5:4 are not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus | input | 16 | Shared configuration/data bus |
| cfg_def | input | 1 | Define strobe, captures the bus while high |
| cfg_word | output | 16 | Stored configuration word |
| cfg_valid | output | 1 | Decoded fields settled after a define |
| size_log2 | output | 4 | Log2 of transform point count |
| real_data | output | 1 | Real-input transform |
| two_dim | output | 1 | 16x16 two-dimensional transform |
| shift_later | output | 2 | Right shifts in passes after the first |
| max_left | output | 4 | Largest compensating left shift |
| win_sel | output | 2 | Window choice, 0 rectangular |
| inverse | output | 1 | Inverse transform |
| overlap | output | 2 | Block overlap amount |
| in_div | output | 2 | Input strobe divider |
| dual_real | output | 1 | Real data from two sources |
| dev_mode | output | 2 | Multi-device mode |
| stage_isolate | output | 1 | Transfers kept apart from transform |
| concurrent_ok | output | 1 | Load, transform and dump may overlap |
| test_mode | output | 1 | Illegal combination, test mode entered |

## Verification
A corrupted capture register or strobe-history flop shows at the ports on the edge right after the define strobe falls: either `cfg_valid` fails to rise or `cfg_word` differs from the word driven. A decode fault in any field shows in the same cycle as `cfg_valid` rises, so every scenario compares all outputs there, and again after idle cycles of bus noise to catch an unwanted recapture.

// File: rtl/xform_mode_pkg.sv
package xform_mode_pkg;
  localparam int WORD_W   = 16;
  localparam int SIZE_LSB = 0;
  localparam int SHIFT_B  = 3;
  localparam int WIN_LSB  = 4;
  localparam int OVL_LSB  = 6;
  localparam int DEV_LSB  = 9;
  localparam int LOG_W    = 4;

  localparam logic [1:0] WIN_RECT = 2'd0;
  localparam logic [1:0] WIN_INV  = 2'd3;
  localparam logic [1:0] OVL_NONE = 2'd0;
  localparam logic [1:0] OVL_HALF = 2'd1;
  localparam logic [1:0] OVL_3Q   = 2'd2;
  localparam logic [1:0] DIV_1    = 2'd0;
  localparam logic [1:0] DIV_2    = 2'd1;
  localparam logic [1:0] DIV_4    = 2'd2;
  localparam logic [1:0] DEV_ISO  = 2'd3;
  localparam logic [LOG_W-1:0] LOG_MAX = 4'd10;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [LOG_W-1:0]  size_log2;
    logic              real_data;
    logic              two_dim;
    logic [1:0]        shift_later;
    logic [3:0]        max_left;
    logic [1:0]        win_sel;
    logic              inverse;
    logic [1:0]        overlap;
    logic [1:0]        in_div;
    logic              dual_real;
    logic [1:0]        dev_mode;
    logic              stage_isolate;
    logic              concurrent_ok;
    logic              test_mode;
  } mode_fields_t;

  localparam mode_fields_t MODE_RST = '{
    word: '0, size_log2: 4'd8, real_data: 1'b0, two_dim: 1'b0,
    shift_later: 2'd3, max_left: 4'd15, win_sel: WIN_RECT, inverse: 1'b0,
    overlap: OVL_NONE, in_div: DIV_1, dual_real: 1'b0, dev_mode: 2'd0,
    stage_isolate: 1'b0, concurrent_ok: 1'b1, test_mode: 1'b0};
endpackage

// File: rtl/mode_word_latch.sv
module mode_word_latch
  import xform_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] bus_i,
  input  logic              def_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic def_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= '0;
      def_d   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      def_d <= def_i;
      if (def_i) begin
        word_o  <= bus_i;
        valid_o <= 1'b0;
      end else if (def_d) begin
        valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mode_field_decode.sv
module mode_field_decode
  import xform_mode_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output mode_fields_t      fields_o
);
  logic [2:0] size_c;
  logic [1:0] win_c;
  logic [2:0] ovl_c;
  logic       reserved;

  assign size_c = word_i[SIZE_LSB +: 3];
  assign win_c  = word_i[WIN_LSB +: 2];
  assign ovl_c  = word_i[OVL_LSB +: 3];

  always_comb begin
    fields_o      = MODE_RST;
    fields_o.word = word_i;
    reserved      = 1'b0;

    unique case (size_c)
      3'b000: fields_o.size_log2 = 4'd8;
      3'b001: fields_o.size_log2 = 4'd9;
      3'b010: fields_o.size_log2 = 4'd10;
      3'b011: begin fields_o.size_log2 = 4'd8;  fields_o.two_dim   = 1'b1; end
      3'b100: begin fields_o.size_log2 = 4'd8;  fields_o.real_data = 1'b1; end
      3'b101: begin fields_o.size_log2 = 4'd9;  fields_o.real_data = 1'b1; end
      3'b110: begin fields_o.size_log2 = 4'd10; fields_o.real_data = 1'b1; end
      default: begin fields_o.size_log2 = 4'd8; reserved = 1'b1; end
    endcase

    if (word_i[SHIFT_B]) begin
      fields_o.shift_later = 2'd2;
      fields_o.max_left    = 4'd14;
    end else begin
      fields_o.shift_later = 2'd3;
      fields_o.max_left    = 4'd15;
    end

    fields_o.inverse = (win_c == WIN_INV);
    fields_o.win_sel = fields_o.inverse ? WIN_RECT : win_c;

    unique case (ovl_c)
      3'b000: begin fields_o.overlap = OVL_NONE; fields_o.in_div = DIV_1; fields_o.dual_real = 1'b0; end
      3'b001: begin fields_o.overlap = OVL_HALF; fields_o.in_div = DIV_1; fields_o.dual_real = 1'b0; end
      3'b010: begin fields_o.overlap = OVL_3Q;   fields_o.in_div = DIV_1; fields_o.dual_real = 1'b0; end
      3'b011: begin fields_o.overlap = OVL_HALF; fields_o.in_div = DIV_2; fields_o.dual_real = 1'b0; end
      3'b100: begin fields_o.overlap = OVL_3Q;   fields_o.in_div = DIV_4; fields_o.dual_real = 1'b0; end
      3'b101: begin fields_o.overlap = OVL_NONE; fields_o.in_div = DIV_1; fields_o.dual_real = 1'b1; end
      3'b110: begin fields_o.overlap = OVL_HALF; fields_o.in_div = DIV_1; fields_o.dual_real = 1'b1; end
      default: begin fields_o.overlap = OVL_3Q;  fields_o.in_div = DIV_1; fields_o.dual_real = 1'b1; end
    endcase

    fields_o.dev_mode      = word_i[DEV_LSB +: 2];
    fields_o.stage_isolate = (fields_o.dev_mode == DEV_ISO);
    fields_o.concurrent_ok = (fields_o.size_log2 != LOG_MAX) && !fields_o.dev_mode[1];
    fields_o.test_mode     = reserved || (fields_o.two_dim && (win_c != WIN_RECT));
  end
endmodule

// File: rtl/mode_out_reg.sv
module mode_out_reg
  import xform_mode_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  mode_fields_t d_i,
  output mode_fields_t q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= MODE_RST;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/xform_mode_ctl.sv
module xform_mode_ctl
  import xform_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] cfg_bus,
  input  logic              cfg_def,
  output logic [WORD_W-1:0] cfg_word,
  output logic              cfg_valid,
  output logic [LOG_W-1:0]  size_log2,
  output logic              real_data,
  output logic              two_dim,
  output logic [1:0]        shift_later,
  output logic [3:0]        max_left,
  output logic [1:0]        win_sel,
  output logic              inverse,
  output logic [1:0]        overlap,
  output logic [1:0]        in_div,
  output logic              dual_real,
  output logic [1:0]        dev_mode,
  output logic              stage_isolate,
  output logic              concurrent_ok,
  output logic              test_mode
);
  logic [WORD_W-1:0] word_q;
  mode_fields_t      fields_d;
  mode_fields_t      fields_q;

  mode_word_latch u_latch (
    .clk(clk), .rst(rst), .bus_i(cfg_bus), .def_i(cfg_def),
    .word_o(word_q), .valid_o(cfg_valid)
  );

  mode_field_decode u_dec (.word_i(word_q), .fields_o(fields_d));

  mode_out_reg u_oreg (.clk(clk), .rst(rst), .d_i(fields_d), .q_o(fields_q));

  assign cfg_word      = fields_q.word;
  assign size_log2     = fields_q.size_log2;
  assign real_data     = fields_q.real_data;
  assign two_dim       = fields_q.two_dim;
  assign shift_later   = fields_q.shift_later;
  assign max_left      = fields_q.max_left;
  assign win_sel       = fields_q.win_sel;
  assign inverse       = fields_q.inverse;
  assign overlap       = fields_q.overlap;
  assign in_div        = fields_q.in_div;
  assign dual_real     = fields_q.dual_real;
  assign dev_mode      = fields_q.dev_mode;
  assign stage_isolate = fields_q.stage_isolate;
  assign concurrent_ok = fields_q.concurrent_ok;
  assign test_mode     = fields_q.test_mode;
endmodule

// File: rtl/xform_mode_ctl_chk.sv
module xform_mode_ctl_chk
  import xform_mode_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_def,
  input logic [WORD_W-1:0] cfg_word,
  input logic              cfg_valid,
  input logic [LOG_W-1:0]  size_log2,
  input logic              two_dim,
  input logic [1:0]        shift_later,
  input logic [3:0]        max_left,
  input logic [1:0]        win_sel,
  input logic              inverse,
  input logic [1:0]        overlap,
  input logic [1:0]        in_div,
  input logic [1:0]        dev_mode,
  input logic              stage_isolate,
  input logic              concurrent_ok,
  input logic              test_mode
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_def && !$past(cfg_def)) |=> $stable(cfg_word));

  assert_valid_low_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_def |=> !cfg_valid);

  assert_valid_rise_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_def) && !cfg_def) |=> cfg_valid);

  assert_shift_pair_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_later == 2'd3) == (max_left == 4'd15));

  assert_inverse_rect_R6: assert property (@(posedge clk) disable iff (rst)
    inverse |-> (win_sel == WIN_RECT));

  assert_divider_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    (in_div != DIV_1) |-> (overlap == in_div));

  assert_isolate_R8: assert property (@(posedge clk) disable iff (rst)
    stage_isolate |-> (dev_mode == DEV_ISO && !concurrent_ok));

  assert_sequential_R9: assert property (@(posedge clk) disable iff (rst)
    (size_log2 == LOG_MAX) |-> !concurrent_ok);

  assert_test_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (two_dim && (win_sel != WIN_RECT || inverse)) |-> test_mode);
endmodule

bind xform_mode_ctl xform_mode_ctl_chk u_chk (
  .clk(clk), .rst(rst), .cfg_def(cfg_def), .cfg_word(cfg_word),
  .cfg_valid(cfg_valid), .size_log2(size_log2), .two_dim(two_dim),
  .shift_later(shift_later), .max_left(max_left), .win_sel(win_sel),
  .inverse(inverse), .overlap(overlap), .in_div(in_div),
  .dev_mode(dev_mode), .stage_isolate(stage_isolate),
  .concurrent_ok(concurrent_ok), .test_mode(test_mode)
);

// File: tb/test_xform_mode_ctl.sv
module test_xform_mode_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_bus = '0;
  logic        cfg_def = 1'b0;
  logic [15:0] cfg_word;
  logic        cfg_valid;
  logic [3:0]  size_log2;
  logic        real_data, two_dim, inverse, dual_real;
  logic [1:0]  shift_later, win_sel, overlap, in_div, dev_mode;
  logic [3:0]  max_left;
  logic        stage_isolate, concurrent_ok, test_mode;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  xform_mode_ctl i_xform_mode_ctl (
    .clk(clk), .rst(rst), .cfg_bus(cfg_bus), .cfg_def(cfg_def),
    .cfg_word(cfg_word), .cfg_valid(cfg_valid), .size_log2(size_log2),
    .real_data(real_data), .two_dim(two_dim), .shift_later(shift_later),
    .max_left(max_left), .win_sel(win_sel), .inverse(inverse),
    .overlap(overlap), .in_div(in_div), .dual_real(dual_real),
    .dev_mode(dev_mode), .stage_isolate(stage_isolate),
    .concurrent_ok(concurrent_ok), .test_mode(test_mode)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int e_log2(logic [2:0] c);
    if (c == 3'd1 || c == 3'd5) return 9;
    if (c == 3'd2 || c == 3'd6) return 10;
    return 8;
  endfunction

  function automatic int e_ovl(logic [2:0] c);
    int t[8] = '{0, 1, 2, 1, 2, 0, 1, 2};
    return t[c];
  endfunction

  function automatic int e_div(logic [2:0] c);
    if (c == 3'd3) return 1;
    if (c == 3'd4) return 2;
    return 0;
  endfunction

  task automatic check_all(logic [15:0] w);
    logic [2:0] sz = w[2:0];
    logic [1:0] wn = w[5:4];
    logic [2:0] ov = w[8:6];
    logic [1:0] dm = w[10:9];
    chk("R3", "valid", int'(cfg_valid), 1);
    chk("R2", "word", int'(cfg_word), int'(w));
    chk("R4", "size_log2", int'(size_log2), e_log2(sz));
    chk("R4", "real_data", int'(real_data), int'(sz >= 3'd4 && sz <= 3'd6));
    chk("R4", "two_dim", int'(two_dim), int'(sz == 3'd3));
    chk("R5", "shift_later", int'(shift_later), w[3] ? 2 : 3);
    chk("R5", "max_left", int'(max_left), w[3] ? 14 : 15);
    chk("R6", "win_sel", int'(win_sel), (wn == 2'd3) ? 0 : int'(wn));
    chk("R6", "inverse", int'(inverse), int'(wn == 2'd3));
    chk("R7", "overlap", int'(overlap), e_ovl(ov));
    chk("R7", "in_div", int'(in_div), e_div(ov));
    chk("R7", "dual_real", int'(dual_real), int'(ov >= 3'd5));
    chk("R8", "dev_mode", int'(dev_mode), int'(dm));
    chk("R8", "stage_isolate", int'(stage_isolate), int'(dm == 2'd3));
    chk("R9", "concurrent_ok", int'(concurrent_ok),
        int'(e_log2(sz) != 10 && dm <= 2'd1));
    chk("R10", "test_mode", int'(test_mode),
        int'(sz == 3'd7 || (sz == 3'd3 && wn != 2'd0)));
  endtask

  // One define pulse, then checks on the edge after the strobe falls.
  task automatic apply(logic [15:0] w);
    @(negedge clk);
    cfg_bus = w;
    cfg_def = 1'b1;
    @(negedge clk);
    cfg_def = 1'b0;
    cfg_bus = ~w;
    chk("R3", "valid during define", int'(cfg_valid), 0);
    @(negedge clk);
    check_all(w);
  endtask

  task automatic t_reset();
    chk("R1", "valid", int'(cfg_valid), 0);
    chk("R1", "word", int'(cfg_word), 0);
    chk("R1", "size_log2", int'(size_log2), 8);
    chk("R1", "shift_later", int'(shift_later), 3);
    chk("R1", "max_left", int'(max_left), 15);
    chk("R1", "win/inv", int'({win_sel, inverse}), 0);
    chk("R1", "ovl/div/dual", int'({overlap, in_div, dual_real}), 0);
    chk("R1", "dev/iso", int'({dev_mode, stage_isolate}), 0);
    chk("R1", "concurrent_ok", int'(concurrent_ok), 1);
    chk("R1", "test_mode", int'(test_mode), 0);
  endtask

  task automatic t_sizes();
    for (int c = 0; c < 8; c++) apply(16'(c));
  endtask

  task automatic t_shift();
    apply(16'h0008);
    apply(16'h0001);
  endtask

  task automatic t_window();
    for (int wv = 0; wv < 4; wv++) begin
      apply(16'(wv << 4));
      apply(16'((wv << 4) | 3));
    end
  endtask

  task automatic t_overlap();
    for (int c = 0; c < 8; c++) apply(16'((c << 6) | 1));
  endtask

  task automatic t_devmode();
    for (int d = 0; d < 4; d++) begin
      apply(16'(d << 9));
      apply(16'((d << 9) | 2));
      apply(16'((d << 9) | 6));
    end
  endtask

  task automatic t_hold();
    logic [15:0] w = 16'hA5D1;
    apply(w);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cfg_bus = 16'h1234 + 16'(k * 16'h1111);
    end
    @(negedge clk);
    chk("R2", "word held with define low", int'(cfg_word), int'(w));
    chk("R2", "valid held", int'(cfg_valid), 1);
    check_all(w);
  endtask

  task automatic t_long_define();
    @(negedge clk);
    cfg_def = 1'b1;
    cfg_bus = 16'h0111;
    @(negedge clk);
    chk("R3", "valid low, define cycle 1", int'(cfg_valid), 0);
    cfg_bus = 16'h0222;
    @(negedge clk);
    chk("R3", "valid low, define cycle 2", int'(cfg_valid), 0);
    cfg_bus = 16'hF64B;
    @(negedge clk);
    chk("R3", "valid low, define cycle 3", int'(cfg_valid), 0);
    cfg_def = 1'b0;
    cfg_bus = 16'h0000;
    @(negedge clk);
    check_all(16'hF64B);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sizes();
    t_shift();
    t_window();
    t_overlap();
    t_devmode();
    t_hold();
    t_long_define();
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule